// File: doc/BRIEF.md
# Split-Accumulator Multiply-Accumulate Engine

This block multiplies two operand words and folds the product into a double-width accumulator. The accumulator is held as a high half and a low half. Software issues one operation per `start_i` pulse. Each operation does one of the following:

- accumulates the product, signed or unsigned;
- subtracts the product from the accumulator, signed or unsigned;
- accumulates against a sign-extended short immediate;
- replaces the accumulator with a full-width product, signed or unsigned;
- drains the low half and clears the whole accumulator.

Each arithmetic operation keeps a sticky-free status flag up to date. Signed forms update the overflow flag and unsigned forms update the carry flag. The block also raises a one-cycle range-exception request when the updated flag is set and the exception enable, sampled when the operation is issued, is 1.

The multiplier is chosen by a parameter. It is either an iterative shift-add engine taking `DW` cycles, or a single registered stage. While a product is in flight, `busy_o` is high and new starts are dropped. The register file and the exception vector logic belong to the surrounding core.

Top module: `acc_mult_unit`

## Requirements
- R1: After reset, `acc_o`, `ov_o`, `cy_o`, `busy_o`, `done_o`, `range_o` and `rd_o` are all zero.
- R2: Op code 0 adds the signed product of `a_i` and `b_i` to the accumulator modulo 2^(2·DW). It sets `ov_o` exactly when the true signed sum lies outside the signed 2·DW-bit range, and leaves `cy_o` unchanged.
- R3: Op code 1 adds the unsigned product to the accumulator. It sets `cy_o` exactly when the true sum is 2^(2·DW) or more, and leaves `ov_o` unchanged.
- R4: Op code 2 subtracts the signed product from the accumulator. It sets `ov_o` exactly when the true signed difference is out of range, and leaves `cy_o` unchanged.
- R5: Op code 3 subtracts the unsigned product from the accumulator. It sets `cy_o` exactly when the product exceeds the accumulator (a borrow), and leaves `ov_o` unchanged.
- R6: Op code 4 behaves like op code 0, except that the second operand is `imm_i` sign-extended to DW bits; `b_i` is ignored.
- R7: Op code 5 (signed) and op code 6 (unsigned) overwrite the whole accumulator with the 2·DW-bit product, and leave both flags unchanged.
- R8: Op code 7, accepted while idle, loads `rd_o` with the prior low half (accumulator bits DW-1:0). It clears the whole accumulator and pulses `done_o` in the next cycle. It never raises `busy_o` and leaves the flags unchanged.
- R9: An arithmetic op sets `busy_o` from the cycle after acceptance until the cycle in which the result is written, and `done_o` pulses in that cycle. A `start_i` seen while `busy_o` is high has no effect, and the accumulator changes only when the result is written.
- R10: `range_o` pulses together with `done_o` only for op codes 0–4, and only when the flag that op updates is 1 after the update and `ove_i` was 1 at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue an operation; taken only while `busy_o` is low |
| op_i | input | 3 | Operation code, see R2–R8 |
| a_i | input | DW | First operand |
| b_i | input | DW | Second operand (register forms) |
| imm_i | input | IMM_W | Short immediate for op code 4 |
| ove_i | input | 1 | Range-exception enable, sampled at acceptance |
| busy_o | output | 1 | Multiplier in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rd_o | output | DW | Low half captured by the last drain |
| acc_o | output | 2·DW | Accumulator {high, low} |
| ov_o | output | 1 | Signed overflow flag |
| cy_o | output | 1 | Unsigned carry/borrow flag |
| range_o | output | 1 | Range-exception request pulse |

## Verification
The assertions rely on the environment never raising `start_i` while `busy_o` is high with the expectation that it is taken. They also take the multiplier's start to arrive only when its step counter is idle. The stimulus issues each operation at a falling edge, drops `start_i` one cycle later and waits for `done_o` before issuing the next. The single exception is a deliberate collision test, which holds a start against a busy unit and checks that it leaves no trace. All operand pairs of a four-bit configuration are swept for each op code. The accumulator is carried across operations, and drains are interleaved so that signed and unsigned overflow, borrow and the immediate sign bit are all reached.

// File: rtl/acc_mult_pkg.sv
package acc_mult_pkg;

   typedef enum logic [2:0] {
      OP_ACC_S  = 3'd0,
      OP_ACC_U  = 3'd1,
      OP_SUB_S  = 3'd2,
      OP_SUB_U  = 3'd3,
      OP_ACC_IM = 3'd4,
      OP_MUL_S  = 3'd5,
      OP_MUL_U  = 3'd6,
      OP_DRAIN  = 3'd7
   } acc_op_e;

   function automatic logic op_signed(input acc_op_e op);
      return (op == OP_ACC_S) || (op == OP_SUB_S) || (op == OP_ACC_IM) || (op == OP_MUL_S);
   endfunction

   function automatic logic op_is_mul(input acc_op_e op);
      return (op == OP_MUL_S) || (op == OP_MUL_U);
   endfunction

endpackage

// File: rtl/acc_mult_core.sv
module acc_mult_core #(
   parameter int DW        = 32,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic [DW-1:0]   a_i,
   input  logic [DW-1:0]   b_i,
   input  logic            sgn_i,
   output logic            done_o,
   output logic [2*DW-1:0] prod_o
);
   localparam int PW = 2 * DW;

   function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] x, input logic s);
      return (s && x[DW-1]) ? (~x + 1'b1) : x;
   endfunction

   logic [DW-1:0] mag_a, mag_b;
   logic [PW-1:0] part_q;
   logic          neg_q;
   logic          done_q;

   assign mag_a  = magnitude(a_i, sgn_i);
   assign mag_b  = magnitude(b_i, sgn_i);
   assign prod_o = neg_q ? (~part_q + 1'b1) : part_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    neg_q <= 1'b0;
      else if (go_i) neg_q <= sgn_i & (a_i[DW-1] ^ b_i[DW-1]);
   end

   generate
      if (ITERATIVE) begin : g_iter
         localparam int CW = $clog2(DW + 1);
         logic [PW-1:0] mcand_q;
         logic [DW-1:0] mplier_q;
         logic [CW-1:0] steps_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mcand_q  <= '0;
               mplier_q <= '0;
               steps_q  <= '0;
               part_q   <= '0;
               done_q   <= 1'b0;
            end else if (go_i) begin
               mcand_q  <= {{DW{1'b0}}, mag_a};
               mplier_q <= mag_b;
               steps_q  <= CW'(DW);
               part_q   <= '0;
               done_q   <= 1'b0;
            end else if (steps_q != '0) begin
               if (mplier_q[0]) part_q <= part_q + mcand_q;
               mcand_q  <= mcand_q << 1;
               mplier_q <= mplier_q >> 1;
               steps_q  <= steps_q - 1'b1;
               done_q   <= (steps_q == CW'(1));
            end else begin
               done_q   <= 1'b0;
            end
         end

         assert_go_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            go_i |-> (steps_q == '0));
      end else begin : g_flat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               part_q <= '0;
               done_q <= 1'b0;
            end else begin
               if (go_i) part_q <= {{DW{1'b0}}, mag_a} * {{DW{1'b0}}, mag_b};
               done_q <= go_i;
            end
         end

         assert_go_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            go_i |-> !done_q);
      end
   endgenerate

endmodule

// File: rtl/acc_mult_fold.sv
module acc_mult_fold
   import acc_mult_pkg::*;
#(
   parameter int DW = 32
) (
   input  acc_op_e         op_i,
   input  logic [2*DW-1:0] acc_i,
   input  logic [2*DW-1:0] prod_i,
   input  logic            ov_i,
   input  logic            cy_i,
   output logic [2*DW-1:0] acc_o,
   output logic            ov_o,
   output logic            cy_o,
   output logic            hit_o
);
   localparam int PW = 2 * DW;

   logic [PW:0] sum_w, dif_w;
   logic        a_msb, p_msb;

   assign sum_w = {1'b0, acc_i} + {1'b0, prod_i};
   assign dif_w = {1'b0, acc_i} - {1'b0, prod_i};
   assign a_msb = acc_i[PW-1];
   assign p_msb = prod_i[PW-1];

   always_comb begin
      acc_o = acc_i;
      ov_o  = ov_i;
      cy_o  = cy_i;
      hit_o = 1'b0;
      unique case (op_i)
         OP_ACC_S, OP_ACC_IM: begin
            acc_o = sum_w[PW-1:0];
            ov_o  = (a_msb == p_msb) && (sum_w[PW-1] != a_msb);
            hit_o = ov_o;
         end
         OP_ACC_U: begin
            acc_o = sum_w[PW-1:0];
            cy_o  = sum_w[PW];
            hit_o = cy_o;
         end
         OP_SUB_S: begin
            acc_o = dif_w[PW-1:0];
            ov_o  = (a_msb != p_msb) && (dif_w[PW-1] != a_msb);
            hit_o = ov_o;
         end
         OP_SUB_U: begin
            acc_o = dif_w[PW-1:0];
            cy_o  = dif_w[PW];
            hit_o = cy_o;
         end
         OP_MUL_S, OP_MUL_U: acc_o = prod_i;
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_mult_unit.sv
module acc_mult_unit
   import acc_mult_pkg::*;
#(
   parameter int DW        = 32,
   parameter int IMM_W     = 16,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [2:0]       op_i,
   input  logic [DW-1:0]    a_i,
   input  logic [DW-1:0]    b_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             ove_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [DW-1:0]    rd_o,
   output logic [2*DW-1:0]  acc_o,
   output logic             ov_o,
   output logic             cy_o,
   output logic             range_o
);
   localparam int PW = 2 * DW;

   generate
      if (DW < 2)      begin : g_bad_dw  $error("acc_mult_unit: DW must be at least 2"); end
      if (IMM_W < 1)   begin : g_bad_imm $error("acc_mult_unit: IMM_W must be at least 1"); end
      if (IMM_W > DW)  begin : g_wide    $error("acc_mult_unit: IMM_W may not exceed DW"); end
   endgenerate

   acc_op_e       op_in, op_q;
   logic [DW-1:0] imm_ext, b_sel;
   logic [PW-1:0] acc_q, prod_w, acc_nx;
   logic          ov_q, cy_q, ov_nx, cy_nx, hit_w;
   logic          busy_q, done_q, rng_q, ove_q;
   logic [DW-1:0] rd_q;
   logic          take, take_drain, go, mul_done;

   assign op_in = acc_op_e'(op_i);

   generate
      if (IMM_W < DW) begin : g_sext
         assign imm_ext = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      end else begin : g_same
         assign imm_ext = imm_i;
      end
   endgenerate

   assign b_sel      = (op_in == OP_ACC_IM) ? imm_ext : b_i;
   assign take       = start_i && !busy_q;
   assign take_drain = take && (op_in == OP_DRAIN);
   assign go         = take && (op_in != OP_DRAIN);

   acc_mult_core #(.DW(DW), .ITERATIVE(ITERATIVE)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go),
      .a_i    (a_i),
      .b_i    (b_sel),
      .sgn_i  (op_signed(op_in)),
      .done_o (mul_done),
      .prod_o (prod_w)
   );

   acc_mult_fold #(.DW(DW)) u_fold (
      .op_i   (op_q),
      .acc_i  (acc_q),
      .prod_i (prod_w),
      .ov_i   (ov_q),
      .cy_i   (cy_q),
      .acc_o  (acc_nx),
      .ov_o   (ov_nx),
      .cy_o   (cy_nx),
      .hit_o  (hit_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         ov_q   <= 1'b0;
         cy_q   <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rng_q  <= 1'b0;
         ove_q  <= 1'b0;
         rd_q   <= '0;
         op_q   <= OP_ACC_S;
      end else begin
         done_q <= 1'b0;
         rng_q  <= 1'b0;
         if (take_drain) begin
            rd_q   <= acc_q[DW-1:0];
            acc_q  <= '0;
            done_q <= 1'b1;
         end else if (go) begin
            busy_q <= 1'b1;
            op_q   <= op_in;
            ove_q  <= ove_i;
         end
         if (mul_done) begin
            acc_q  <= acc_nx;
            ov_q   <= ov_nx;
            cy_q   <= cy_nx;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            rng_q  <= ove_q & hit_w;
         end
      end
   end

   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign rd_o    = rd_q;
   assign acc_o   = acc_q;
   assign ov_o    = ov_q;
   assign cy_o    = cy_q;
   assign range_o = rng_q;

   assert_drain_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_drain |=> (acc_q == '0) && done_q && !busy_q);

   assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !mul_done) |=> $stable(acc_q));

   assert_core_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mul_done |-> busy_q);

   assert_range_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rng_q |-> (done_q && (ov_q || cy_q)));

   assert_mul_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_done && op_is_mul(op_q)) |=> ($stable(ov_q) && $stable(cy_q) && !rng_q));

endmodule

// File: tb/acc_mult_unit_test.sv
module acc_mult_unit_test;
   localparam int DW    = 4;
   localparam int IMM_W = 3;
   localparam int PW    = 2 * DW;
   localparam int AMAX  = 1 << PW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [2:0]       op_i = '0;
   logic [DW-1:0]    a_i = '0, b_i = '0;
   logic [IMM_W-1:0] imm_i = '0;
   logic             ove_i = 1'b0;
   logic             busy_o, done_o, ov_o, cy_o, range_o;
   logic [DW-1:0]    rd_o;
   logic [PW-1:0]    acc_o;

   int errors = 0, checks = 0, done_seen = 0;
   int m_acc = 0;
   logic m_ov = 1'b0, m_cy = 1'b0;

   always #10 clk = ~clk;

   acc_mult_unit #(.DW(DW), .IMM_W(IMM_W), .ITERATIVE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .imm_i(imm_i), .ove_i(ove_i), .busy_o(busy_o), .done_o(done_o), .rd_o(rd_o),
      .acc_o(acc_o), .ov_o(ov_o), .cy_o(cy_o), .range_o(range_o));

   always @(negedge clk) if (done_o) done_seen++;

   function automatic int sval(input int v, input int w);
      return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input int op, input int a, input int b, input int imm, input bit ove,
                      input string tag);
      int sa, sb, pu, ps, r, exp_rd;
      bit hit, rng;
      int guard;
      sa = sval(a, DW);
      sb = (op == 4) ? sval(imm, IMM_W) : sval(b, DW);
      ps = sa * sb;
      pu = a * b;
      hit = 1'b0;
      exp_rd = -1;
      case (op)
         0, 4: begin r = sval(m_acc, PW) + ps; m_ov = (r >= AMAX/2) || (r < -AMAX/2); hit = m_ov; end
         1:    begin r = m_acc + pu; m_cy = (r >= AMAX); hit = m_cy; end
         2:    begin r = sval(m_acc, PW) - ps; m_ov = (r >= AMAX/2) || (r < -AMAX/2); hit = m_ov; end
         3:    begin r = m_acc - pu; m_cy = (r < 0); hit = m_cy; end
         5:    r = ps;
         6:    r = pu;
         default: begin exp_rd = m_acc % (1 << DW); r = 0; end
      endcase
      m_acc = ((r % AMAX) + AMAX) % AMAX;
      rng = ove && hit;
      @(negedge clk);
      op_i = op[2:0]; a_i = DW'(a); b_i = DW'(b); imm_i = IMM_W'(imm); ove_i = ove;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      guard = 0;
      while (!done_o && guard < 100) begin @(negedge clk); guard++; end
      check({tag, " done"}, int'(done_o), 1);
      check({tag, " acc"}, int'(acc_o), m_acc);
      check({tag, " ov"}, int'(ov_o), int'(m_ov));
      check({tag, " cy"}, int'(cy_o), int'(m_cy));
      check({tag, " range"}, int'(range_o), int'(rng));
      check({tag, " busy"}, int'(busy_o), 0);
      if (exp_rd >= 0) check({tag, " rd"}, int'(rd_o), exp_rd);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 acc", int'(acc_o), 0);
      check("R1 ov", int'(ov_o), 0);
      check("R1 cy", int'(cy_o), 0);
      check("R1 busy", int'(busy_o), 0);
      check("R1 done", int'(done_o), 0);
      check("R1 range", int'(range_o), 0);
      check("R1 rd", int'(rd_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2..R5, R7 sweeps; drains (R8) interleaved, R10 via alternating enable
      for (int op = 0; op < 7; op++) begin
         if (op == 4) continue;
         for (int a = 0; a < (1 << DW); a++) begin
            for (int b = 0; b < (1 << DW); b++) begin
               string tag;
               case (op)
                  0: tag = "R2";
                  1: tag = "R3";
                  2: tag = "R4";
                  3: tag = "R5";
                  default: tag = "R7";
               endcase
               run(op, a, b, 0, bit'(a[0] ^ b[1]), tag);
               if (((a * 16 + b) % 37) == 36) run(7, 0, 0, 0, 1'b1, "R8");
            end
         end
      end

      // R6: immediate form, register b must be ignored
      for (int a = 0; a < (1 << DW); a++)
         for (int im = 0; im < (1 << IMM_W); im++)
            run(4, a, (~a) & 15, im, bit'(im[0]), "R6");

      // R8: drain after a known product
      run(6, 13, 11, 0, 1'b0, "R7");
      run(7, 0, 0, 0, 1'b1, "R8");
      run(7, 0, 0, 0, 1'b1, "R8");

      // R9: a start while busy leaves no trace
      run(5, 3, 3, 0, 1'b0, "R7");
      @(negedge clk);
      op_i = 3'd1; a_i = 4'd3; b_i = 4'd5; ove_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      op_i = 3'd5; a_i = 4'd7; b_i = 4'd7;
      check("R9 busy during op", int'(busy_o), 1);
      @(negedge clk);
      start_i = 1'b0;
      seen = done_seen;
      while (!done_o) @(negedge clk);
      m_acc = 9 + 15; m_cy = 1'b0;
      check("R9 first result kept", int'(acc_o), m_acc);
      repeat (3 * DW) @(negedge clk);
      check("R9 single completion", done_seen - seen, 1);
      check("R9 acc unchanged", int'(acc_o), m_acc);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule